// File: doc/BRIEF.md
# Dark-Column Line Clamp

The block sits on one output channel of an interline image sensor readout and processes that channel's serial pixel stream one line at a time. Counting valid pixels from a line-start strobe, it sorts every position into one of five regions: leading dummy shift phases, the shielded dark reference strip, unshielded buffer pixels, active pixels, and overclock positions past the end of the active run. The outermost dark column on each side of the strip can leak light, so only the inner dark columns are trusted. The block sums those inner columns and turns the sum into a rounded average.

The average is subtracted from every active pixel that follows, and the result is clamped at zero. Every other region leaves the block unchanged, and each output carries its region tag. The current dark estimate is also available as an output. The estimate carries over from one line to the next, so a line whose dark strip never completes leaves the previous value in use. The division by the number of trusted columns is a multiply by a fixed reciprocal followed by a shift. When that count is a power of two, a plain shift is used instead.

Top module: `dark_line_clamp`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_vld` is 0 and `dark_level` is 0.
- R2: The k-th valid pixel after a line start (k from 0) gets this region tag: 0 (dummy) for k < DUMMY_N, 1 (dark) for the next DARK_N, 2 (buffer) for the next BUF_N, and 3 (active) for the next ACTIVE_N. Cycles with `pix_vld` low do not advance k.
- R3: `dark_level` is the sum of the inner dark samples divided by N = DARK_N − 2·TRIM_N and rounded to nearest, with ties rounding up (floor((2·sum+N)/(2N))). It takes its new value in the same cycle as the output of the last inner dark sample.
- R4: Dummy pixels, the TRIM_N outer dark columns on each side, buffer pixels, active pixels and overclock pixels have no effect on `dark_level`.
- R5: For region 3, `out_data` = max(pixel − `dark_level`, 0), using the dark level held before that pixel.
- R6: For regions 0, 1, 2 and 4, `out_data` equals the input pixel unchanged.
- R7: Outputs are registered with one cycle of latency. `out_vld` is high exactly one cycle after each cycle in which `pix_vld` is high.
- R8: A line start discards any partial dark sum. A line that ends before its last inner dark sample leaves `dark_level` at the previous line's value.
- R9: A pixel that arrives in the same cycle as `line_start` is position 0 of the new line.
- R10: Every valid pixel after the active run is tagged 4 (overclock) until the next line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_vld | input | 1 | Pixel valid strobe |
| pix_data | input | DW | Raw pixel value |
| line_start | input | 1 | Line-start strobe; resets position and dark sum |
| out_vld | output | 1 | Output pixel valid |
| out_data | output | DW | Corrected (active) or passed-through pixel |
| out_region | output | 3 | Region tag of the output pixel |
| dark_level | output | DW | Current dark estimate |

## Verification
The cases that are hardest to reach from the ports are two. The first is a rounding error in the reciprocal multiply, which only appears for particular dark sums. The second is a wrongly included edge dark column, which is invisible whenever edge and centre values happen to agree. The bench drives a small configuration with five trusted columns, so every sum residue modulo five is reached across many hashed lines. On alternate lines it sets all untrusted positions to full scale, so any leakage into the estimate moves it at once. It also truncates a line inside the dark strip and starts a line with a pixel in the strobe cycle, to reach the carry-over and coincident-start corners.

// File: rtl/dlc_pkg.sv
// Shared types for the dark-column line clamp.
package dlc_pkg;
    // Region of a pixel position within one channel's line.
    typedef enum logic [2:0] {
        REG_DUMMY   = 3'd0,
        REG_DARK    = 3'd1,
        REG_BUFFER  = 3'd2,
        REG_ACTIVE  = 3'd3,
        REG_OVERCLK = 3'd4
    } region_e;
endpackage

// File: rtl/dlc_position.sv
// Position counter and region classifier.
// Counts valid pixels since the last line start and maps the count to a
// region. It also flags the trusted (inner) dark samples and the last one.
// Assumes: line_start in the same cycle as a pixel makes that pixel position 0.
module dlc_position import dlc_pkg::*; #(
    parameter int DUMMY_N  = 11,
    parameter int DARK_N   = 22,
    parameter int TRIM_N   = 1,
    parameter int BUF_N    = 12,
    parameter int ACTIVE_N = 1648
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    vld_i,
    input  logic    start_i,
    output region_e region_o,
    output logic    use_o,
    output logic    last_o
);
    localparam int OVC_LO = DUMMY_N + DARK_N + BUF_N + ACTIVE_N;
    localparam int POS_W  = $clog2(OVC_LO + 1);
    localparam logic [POS_W-1:0] P_DARK   = POS_W'(DUMMY_N);
    localparam logic [POS_W-1:0] P_BUF    = POS_W'(DUMMY_N + DARK_N);
    localparam logic [POS_W-1:0] P_ACT    = POS_W'(DUMMY_N + DARK_N + BUF_N);
    localparam logic [POS_W-1:0] P_OVC    = POS_W'(OVC_LO);
    localparam logic [POS_W-1:0] P_USE_LO = POS_W'(DUMMY_N + TRIM_N);
    localparam logic [POS_W-1:0] P_USE_HI = POS_W'(DUMMY_N + DARK_N - TRIM_N - 1);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_eff;

    // Effective position of the current pixel: a line start restarts at zero.
    assign pos_eff = start_i ? '0 : pos_q;

    // Map the position onto a region tag.
    always_comb begin
        if (pos_eff < P_DARK)      region_o = REG_DUMMY;
        else if (pos_eff < P_BUF)  region_o = REG_DARK;
        else if (pos_eff < P_ACT)  region_o = REG_BUFFER;
        else if (pos_eff < P_OVC)  region_o = REG_ACTIVE;
        else                       region_o = REG_OVERCLK;
    end

    // Flag trusted inner dark columns and the final one.
    always_comb begin
        use_o  = (pos_eff >= P_USE_LO) && (pos_eff <= P_USE_HI);
        last_o = (pos_eff == P_USE_HI);
    end

    // Advance on each valid pixel, saturate in the overclock region.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (vld_i)
            pos_q <= (pos_eff == P_OVC) ? pos_eff : pos_eff + 1'b1;
        else if (start_i)
            pos_q <= '0;
    end

    // Position only grows inside a line (R2).
    p_pos_monotonic_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> pos_q >= $past(pos_q));
    // A pixel in the strobe cycle is position 0, so the next count is 1 (R9).
    p_start_with_pixel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && vld_i) |=> pos_q == POS_W'(1));
    // Overclock holds until the next line start (R10).
    p_overclock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == P_OVC && !start_i) |=> pos_q == P_OVC);
endmodule

// File: rtl/dlc_dark_accum.sv
// Dark accumulator and averager.
// Sums the trusted dark samples of a line and, on the last one, loads the
// rounded average into the dark register. Division by N_USED uses a shift
// when N_USED is a power of two, and otherwise a multiply by a ceiling
// reciprocal, with enough fraction bits to match exact round-half-up.
// Assumes: N_USED >= 1 and DW small enough that the sum fits in 32 bits.
module dlc_dark_accum #(
    parameter int DW     = 12,
    parameter int N_USED = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          vld_i,
    input  logic          use_i,
    input  logic          last_i,
    input  logic [DW-1:0] pix_i,
    output logic [DW-1:0] dark_o
);
    localparam int SUM_MAX = N_USED * ((1 << DW) - 1);
    localparam int SUM_W   = $clog2(SUM_MAX + 1);

    logic [SUM_W-1:0] acc_q;
    logic [SUM_W-1:0] acc_eff;
    logic [SUM_W-1:0] sum_nxt;
    logic [DW-1:0]    avg;

    // Sum including the current sample; a line start drops the old sum.
    assign acc_eff = start_i ? '0 : acc_q;
    assign sum_nxt = acc_eff + SUM_W'(pix_i);

    // Pick the divider variant from the sample count.
    generate
        if ((N_USED & (N_USED - 1)) == 0) begin : g_shift
            localparam int LOG2N = $clog2(N_USED);
            assign avg = DW'(({1'b0, sum_nxt} + (SUM_W+1)'(N_USED / 2)) >> LOG2N);
        end else begin : g_recip
            localparam int SHIFT = $clog2(2 * SUM_MAX * N_USED + 1);
            localparam longint RECIP = ((longint'(1) << SHIFT) + N_USED - 1) / N_USED;
            localparam int PW = SUM_W + SHIFT + 1;
            logic [PW-1:0] prod;
            assign prod = PW'(sum_nxt) * PW'(RECIP) + (PW'(1) << (SHIFT - 1));
            assign avg  = DW'(prod >> SHIFT);
        end
    endgenerate

    // Accumulate trusted samples and load the average on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            dark_o <= '0;
        end else begin
            if (vld_i && use_i)
                acc_q <= sum_nxt;
            else if (start_i)
                acc_q <= '0;
            if (vld_i && last_i)
                dark_o <= avg;
        end
    end

    // The estimate changes only on the last trusted sample (R4, R8).
    p_dark_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld_i && last_i) |=> $stable(dark_o));
    // A bare line start empties the sum (R8).
    p_sum_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !(vld_i && use_i)) |=> acc_q == '0);
    // Loaded value lies within half a step of sum/N (R3).
    p_avg_round_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && last_i) |=>
        (2 * longint'(dark_o) * N_USED <= 2 * longint'($past(sum_nxt)) + N_USED) &&
        (2 * longint'(dark_o) * N_USED + N_USED > 2 * longint'($past(sum_nxt))));
endmodule

// File: rtl/dlc_correct.sv
// Output stage: subtracts the dark level from active pixels, clamped at
// zero, and passes all other regions unchanged. Registers value, tag, valid.
// Assumes: dark_i does not change in a cycle that carries an active pixel.
module dlc_correct import dlc_pkg::*; #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  region_e       region_i,
    input  logic [DW-1:0] pix_i,
    input  logic [DW-1:0] dark_i,
    output logic          out_vld_o,
    output logic [DW-1:0] out_pix_o,
    output region_e       out_tag_o
);
    logic [DW-1:0] corr;

    // Clamped subtraction for active pixels, pass-through otherwise.
    always_comb begin
        if (region_i == REG_ACTIVE)
            corr = (pix_i > dark_i) ? pix_i - dark_i : '0;
        else
            corr = pix_i;
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld_o <= 1'b0;
            out_pix_o <= '0;
            out_tag_o <= REG_DUMMY;
        end else begin
            out_vld_o <= vld_i;
            out_pix_o <= corr;
            out_tag_o <= region_i;
        end
    end

    // A corrected active pixel never exceeds its raw value (R5).
    p_active_not_above_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld_o && out_tag_o == REG_ACTIVE) |-> out_pix_o <= $past(pix_i));
    // Non-active regions leave the value untouched (R6).
    p_passthrough_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld_o && out_tag_o != REG_ACTIVE) |-> out_pix_o == $past(pix_i));
endmodule

// File: rtl/dark_line_clamp.sv
// Dark-column line clamp for one readout channel.
// Classifies each pixel position of a line, averages the inner dark
// columns and subtracts that level from the active pixels that follow.
// Assumes: TRIM_N + BUF_N >= 0 gap, so the dark level settles before the
// first active pixel; DARK_N > 2*TRIM_N.
module dark_line_clamp #(
    parameter int DW       = 12,
    parameter int DUMMY_N  = 11,
    parameter int DARK_N   = 22,
    parameter int TRIM_N   = 1,
    parameter int BUF_N    = 12,
    parameter int ACTIVE_N = 1648
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_vld,
    input  logic [DW-1:0] pix_data,
    input  logic          line_start,
    output logic          out_vld,
    output logic [DW-1:0] out_data,
    output logic [2:0]    out_region,
    output logic [DW-1:0] dark_level
);
    import dlc_pkg::*;

    localparam int N_USED = DARK_N - 2 * TRIM_N;

    region_e region;
    region_e out_tag;
    logic    use_dark;
    logic    last_dark;

    dlc_position #(
        .DUMMY_N(DUMMY_N), .DARK_N(DARK_N), .TRIM_N(TRIM_N),
        .BUF_N(BUF_N), .ACTIVE_N(ACTIVE_N)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .vld_i(pix_vld), .start_i(line_start),
        .region_o(region), .use_o(use_dark), .last_o(last_dark)
    );

    dlc_dark_accum #(.DW(DW), .N_USED(N_USED)) u_dark (
        .clk(clk), .rst_n(rst_n), .start_i(line_start), .vld_i(pix_vld),
        .use_i(use_dark), .last_i(last_dark), .pix_i(pix_data),
        .dark_o(dark_level)
    );

    dlc_correct #(.DW(DW)) u_corr (
        .clk(clk), .rst_n(rst_n), .vld_i(pix_vld), .region_i(region),
        .pix_i(pix_data), .dark_i(dark_level), .out_vld_o(out_vld),
        .out_pix_o(out_data), .out_tag_o(out_tag)
    );

    // Expose the tag as a plain vector.
    assign out_region = out_tag;

    // Output valid tracks input valid with one cycle of latency (R7).
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |=> out_vld);
endmodule

// File: tb/test_dark_line_clamp.sv
// Self-checking bench: small configuration, many hashed lines, arithmetic model.
module test_dark_line_clamp;
    localparam int DW  = 8;
    localparam int DMY = 3;
    localparam int DRK = 7;
    localparam int TRM = 1;
    localparam int BFN = 2;
    localparam int ACT = 6;
    localparam int NU  = DRK - 2 * TRM;
    localparam int TOT = DMY + DRK + BFN + ACT;
    localparam int USE_LO = DMY + TRM;
    localparam int USE_HI = DMY + DRK - TRM - 1;
    localparam int EXTRA = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_vld = 1'b0;
    logic [DW-1:0] pix_data = '0;
    logic          line_start = 1'b0;
    logic          out_vld;
    logic [DW-1:0] out_data;
    logic [2:0]    out_region;
    logic [DW-1:0] dark_level;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    int m_pos = 0;
    int m_acc = 0;
    int m_dark = 0;

    dark_line_clamp #(
        .DW(DW), .DUMMY_N(DMY), .DARK_N(DRK), .TRIM_N(TRM),
        .BUF_N(BFN), .ACTIVE_N(ACT)
    ) i_dark_line_clamp (
        .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_data(pix_data),
        .line_start(line_start), .out_vld(out_vld), .out_data(out_data),
        .out_region(out_region), .dark_level(dark_level)
    );

    always #10 clk = ~clk;

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_tag(input int p);
        if (p < DMY) return 0;
        if (p < DMY + DRK) return 1;
        if (p < DMY + DRK + BFN) return 2;
        if (p < TOT) return 3;
        return 4;
    endfunction

    // Pixel value: trusted dark columns hashed; other positions full scale on odd lines.
    function automatic int pix_val(input int ln, input int k);
        int h;
        h = ((k * 37 + ln * 101 + 17) * 13 + ln * ln * 7) % 256;
        if (k >= USE_LO && k <= USE_HI) return h;
        if (ln % 2 == 1) return 255;
        return h;
    endfunction

    // Drive one valid pixel, update the model, check outputs one cycle later.
    task automatic send(input int val, input bit ls);
        int t, ep;
        if (ls) begin m_pos = 0; m_acc = 0; end
        t = exp_tag(m_pos);
        if (t == 3) ep = (val > m_dark) ? val - m_dark : 0;
        else ep = val;
        if (m_pos >= USE_LO && m_pos <= USE_HI) begin
            m_acc += val;
            if (m_pos == USE_HI) m_dark = (2 * m_acc + NU) / (2 * NU);
        end
        if (m_pos < TOT) m_pos++;
        pix_vld = 1'b1; pix_data = DW'(val); line_start = ls;
        @(negedge clk);
        pix_vld = 1'b0; line_start = 1'b0;
        check_eq("R7 out_vld", int'(out_vld), 1);
        check_eq(ls ? "R9 region at coincident start" : (t == 4 ? "R10 overclock tag" : "R2 region tag"),
                 int'(out_region), t);
        check_eq(t == 3 ? "R5 corrected active" : "R6 passthrough", int'(out_data), ep);
        check_eq("R3 dark level", int'(dark_level), m_dark);
    endtask

    task automatic idle();
        pix_vld = 1'b0; line_start = 1'b0;
        @(negedge clk);
        check_eq("R7 idle out_vld", int'(out_vld), 0);
    endtask

    task automatic start_only();
        m_pos = 0; m_acc = 0;
        line_start = 1'b1; pix_vld = 1'b0;
        @(negedge clk);
        line_start = 1'b0;
        check_eq("R7 strobe-only out_vld", int'(out_vld), 0);
        check_eq("R8 dark kept over strobe", int'(dark_level), m_dark);
    endtask

    task automatic run_line(input int ln, input int n_pix, input bit ls_first, input int gap);
        if (!ls_first) start_only();
        for (int k = 0; k < n_pix; k++) begin
            send(pix_val(ln, k), ls_first && k == 0);
            if (gap > 0 && (k % gap) == gap - 1) idle();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        check_eq("R1 out_vld in reset", int'(out_vld), 0);
        check_eq("R1 dark in reset", int'(dark_level), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 out_vld after reset", int'(out_vld), 0);
        check_eq("R1 dark after reset", int'(dark_level), 0);

        // Sweep of full lines with varied gaps, start styles and edge values.
        for (int ln = 0; ln < 60; ln++)
            run_line(ln, TOT + EXTRA, (ln % 3) == 0, ln % 4);

        // Line cut inside the dark strip: partial sum must be dropped (R8).
        held = m_dark;
        run_line(200, USE_HI, 1'b0, 0);
        check_eq("R8 truncated line keeps prior dark", int'(dark_level), held);
        run_line(201, TOT + 1, 1'b0, 0);
        check_eq("R4 dark from inner columns only", int'(dark_level), m_dark);

        // Truncated line followed by coincident-start line (R8, R9).
        run_line(202, USE_LO + 2, 1'b1, 0);
        run_line(203, TOT, 1'b1, 2);

        // Dark-rounding sweep over many centre sums (R3).
        for (int ln = 300; ln < 340; ln++)
            run_line(ln, USE_HI + 1 + TRM + BFN + 1, 1'b0, 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule